// File: doc/BRIEF.md
# Recursive Eight-Sample Running-Sum Filter

This block produces a moving sum over the last eight accepted input samples. It does not hold the samples in a parallel register bank feeding an adder tree. Each accepted sample is added once into an accumulator. The same sample is taken out again when it emerges from the end of an eight-stage delay line. The storage is therefore a plain delay with one output tap, and the arithmetic is one subtraction followed by one accumulation.

A producer drives a signed sample together with a strobe. In every clock cycle where the strobe is high, the delay line advances by one step and the accumulator absorbs the difference between the new sample and the sample leaving the line. In cycles without the strobe, nothing changes. The registered sum appears one clock after the sample. A registered copy of the strobe marks the cycle in which the updated sum is presented. The output can be used as a coarse low-pass smoother, or divided downstream to give a mean.

Top module: `rsum_filter`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after a clock edge that samples it high, `sum_out` is 0 and `sum_valid` is 0.
- R2: After a clock edge at which `in_valid` is 1, `sum_out` holds the two's-complement sum of the most recent eight accepted samples, this one included, read as a signed 19-bit value.
- R3: Until eight samples have been accepted since reset, the missing older samples count as zero. `sum_out` is then the sum of all samples accepted so far.
- R4: A clock edge with `in_valid` at 0 leaves `sum_out` unchanged and does not advance the history. Samples presented without the strobe never enter any later sum.
- R5: `sum_valid` equals the value `in_valid` had at the previous clock edge, so it rises in the same cycle that the updated sum appears.
- R6: Full-scale inputs do not overflow. Eight samples of -32768 give -262144, and eight samples of 32767 give 262136. The sum stays within that range at all times.
- R7: The per-sample difference between the newest sample and the departing sample is formed without wrap. For example, 32767 entering while -32768 leaves raises the sum by exactly 65535.
- R8: A reset in the middle of a stream discards all earlier history, and summation restarts as described in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; the sample is accepted at the clock edge when this is 1 |
| in_sample | input | 16 | Signed two's-complement input sample |
| sum_out | output | 19 | Signed running sum of the last eight accepted samples |
| sum_valid | output | 1 | Registered copy of `in_valid`, aligned with the updated sum |

## Verification
Both results of this block are due exactly one clock edge after the stimulus. The sum and the valid flag come from a single register stage. The delay line adds no output latency, because it only decides which value gets subtracted. The bench changes inputs on the falling edge and lets one rising edge pass. It then compares both outputs on the next falling edge against a reference window kept in the bench. It makes this comparison on every cycle, including strobe-free cycles, where the sum must read the same as before. Reset, start-up fill, gaps, full-scale extremes, alternating extremes and a long pseudo-random stream with irregular strobes are all checked with this same one-edge alignment.

// File: rtl/rsum_pkg.sv
package rsum_pkg;

    parameter int unsigned RSUM_DATA_W = 16;
    parameter int unsigned RSUM_WINDOW = 8;

    function automatic int unsigned rsum_acc_width(input int unsigned data_w,
                                                   input int unsigned window);
        return data_w + $clog2(window);
    endfunction

    parameter int unsigned RSUM_ACC_W = rsum_acc_width(RSUM_DATA_W, RSUM_WINDOW);

endpackage

// File: rtl/rsum_delay_line.sv
module rsum_delay_line #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout_oldest
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] stage;
    } line_t;

    line_t line_d, line_q;

    // Stage 0 takes the new sample; every other stage takes its predecessor.
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_comb begin
                line_d.stage[g] = shift_en ? din : line_q.stage[g];
            end
        end else begin : g_body
            always_comb begin
                line_d.stage[g] = shift_en ? line_q.stage[g-1] : line_q.stage[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    // The only tap: the sample that entered DEPTH accepted steps ago.
    assign dout_oldest = line_q.stage[DEPTH-1];

endmodule

// File: rtl/rsum_diff.sv
module rsum_diff #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned OUT_W  = 19
) (
    input  logic [DATA_W-1:0] newest,
    input  logic [DATA_W-1:0] departing,
    output logic [OUT_W-1:0]  delta
);

    localparam int unsigned DIFF_W = DATA_W + 1;
    localparam int unsigned EXT_W  = OUT_W - DIFF_W;

    logic [DIFF_W-1:0] diff_w;

    always_comb begin
        diff_w = {newest[DATA_W-1], newest} - {departing[DATA_W-1], departing};
    end

    if (EXT_W > 0) begin : g_extend
        assign delta = {{EXT_W{diff_w[DIFF_W-1]}}, diff_w};
    end else begin : g_plain
        assign delta = diff_w[OUT_W-1:0];
    end

endmodule

// File: rtl/rsum_accum.sv
module rsum_accum #(
    parameter int unsigned ACC_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic [ACC_W-1:0] delta,
    output logic [ACC_W-1:0] acc,
    output logic             acc_valid
);

    typedef struct packed {
        logic [ACC_W-1:0] total;
        logic             vld;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d     = acc_q;
        acc_d.vld = step_en;
        if (step_en) begin
            acc_d.total = acc_q.total + delta;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc       = acc_q.total;
    assign acc_valid = acc_q.vld;

endmodule

// File: rtl/rsum_filter.sv
module rsum_filter
    import rsum_pkg::*;
#(
    parameter int unsigned DATA_W = RSUM_DATA_W,
    parameter int unsigned WINDOW = RSUM_WINDOW,
    parameter int unsigned ACC_W  = rsum_acc_width(RSUM_DATA_W, RSUM_WINDOW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic [ACC_W-1:0]  sum_out,
    output logic              sum_valid
);

    logic [DATA_W-1:0] oldest_w;
    logic [ACC_W-1:0]  delta_w;

    rsum_delay_line #(
        .DATA_W (DATA_W),
        .DEPTH  (WINDOW)
    ) u_line (
        .clk         (clk),
        .rst         (rst),
        .shift_en    (in_valid),
        .din         (in_sample),
        .dout_oldest (oldest_w)
    );

    rsum_diff #(
        .DATA_W (DATA_W),
        .OUT_W  (ACC_W)
    ) u_diff (
        .newest    (in_sample),
        .departing (oldest_w),
        .delta     (delta_w)
    );

    rsum_accum #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk       (clk),
        .rst       (rst),
        .step_en   (in_valid),
        .delta     (delta_w),
        .acc       (sum_out),
        .acc_valid (sum_valid)
    );

endmodule

// File: rtl/rsum_filter_chk.sv
module rsum_filter_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned WINDOW = 8,
    parameter int unsigned ACC_W  = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [ACC_W-1:0]  sum_out,
    input logic              sum_valid
);

    localparam longint SAMPLE_MAX = (longint'(1) << (DATA_W - 1)) - 1;
    localparam longint SAMPLE_MIN = -(longint'(1) << (DATA_W - 1));
    localparam longint SUM_MAX    = SAMPLE_MAX * WINDOW;
    localparam longint SUM_MIN    = SAMPLE_MIN * WINDOW;
    localparam longint STEP_MAX   = SAMPLE_MAX - SAMPLE_MIN;

    longint sum_s;
    assign sum_s = longint'($signed(sum_out));

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (sum_out == '0 && !sum_valid)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(sum_out)); // R4

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> sum_valid); // R5

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !sum_valid); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        sum_valid |-> (sum_s <= SUM_MAX && sum_s >= SUM_MIN)); // R6

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((sum_s - longint'($signed($past(sum_out)))) <= STEP_MAX &&
                      (sum_s - longint'($signed($past(sum_out)))) >= -STEP_MAX)); // R7

endmodule

bind rsum_filter rsum_filter_chk #(
    .DATA_W (DATA_W),
    .WINDOW (WINDOW),
    .ACC_W  (ACC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .sum_out   (sum_out),
    .sum_valid (sum_valid)
);

// File: tb/rsum_filter_tb.sv
`timescale 1ns/1ps
module rsum_filter_tb;

    localparam int DW  = 16;
    localparam int WIN = 8;
    localparam int AW  = 19;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [DW-1:0] in_sample;
    logic [AW-1:0] sum_out;
    logic          sum_valid;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int hist [WIN];
    int head;
    int exp_sum;

    always #2.5 clk = ~clk;

    rsum_filter u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .sum_out   (sum_out),
        .sum_valid (sum_valid)
    );

    task automatic model_clear();
        for (int i = 0; i < WIN; i++) hist[i] = 0;
        head    = 0;
        exp_sum = 0;
    endtask

    task automatic check(input string req, input int act, input int exp_v);
        n_vec++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Drive at the falling edge, let one rising edge register it, compare at the next falling edge.
    task automatic step(input bit v, input int s, input string req);
        in_valid  = v;
        in_sample = DW'(s);
        if (v) begin
            exp_sum    = exp_sum - hist[head] + s;
            hist[head] = s;
            head       = (head + 1) % WIN;
        end
        @(posedge clk);
        @(negedge clk);
        check(req, $signed(sum_out), exp_sum);
        check({req, "_valid"}, int'(sum_valid), int'(v));
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        in_valid = 1'b0;
        in_sample = '0;
        @(posedge clk);
        @(negedge clk);
        check("R1", $signed(sum_out), 0);
        check("R1_valid", int'(sum_valid), 0);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        @(negedge clk);
        do_reset();

        // R3: partial fill with a ramp, then R2 steady sliding window
        for (int i = 1; i <= 20; i++) step(1'b1, i * 100, (i < WIN) ? "R3" : "R2");

        // R4: gaps with garbage samples present must not alter anything
        for (int i = 0; i < 5; i++) step(1'b0, 12345, "R4");
        step(1'b1, -7, "R4");
        for (int i = 0; i < 3; i++) step(1'b0, -32768, "R4");
        for (int i = 0; i < WIN; i++) step(1'b1, 0, "R4");

        // R6: full-scale negative and positive windows
        for (int i = 0; i < WIN; i++) step(1'b1, -32768, "R6");
        check("R6_min", $signed(sum_out), -262144);
        for (int i = 0; i < WIN; i++) step(1'b1, 32767, "R6");
        check("R6_max", $signed(sum_out), 262136);

        // R7: extremes swapping in and out (differences of +/-65535)
        for (int i = 0; i < WIN; i++) step(1'b1, -32768, "R7");
        for (int i = 0; i < 3 * WIN; i++) step(1'b1, ((i / WIN) % 2 == 0) ? 32767 : -32768, "R7");

        // R8: reset mid-stream, then restart from an empty window
        step(1'b1, 999, "R8");
        do_reset();
        for (int i = 0; i < WIN + 2; i++) step(1'b1, 3 - i, "R8");

        // R5 and R2: long pseudo-random stream with irregular strobe
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 6000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[31:29] != 3'b000, int'($signed(lfsr[15:0])), "R5");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule